// File: doc/BRIEF.md
# Serial Flash Status and Identification Responder

This block is the target side of a serial flash control path. It holds an eight-bit status register and answers the identification and status opcodes a host issues over a four-wire SPI link in mode 0. The storage array, program and erase sequencing, and multi-lane transfers are not part of it. A sideband input from the erase/program engine drives the busy flag. The host reads that flag through the status opcode.

The SPI pins are oversampled by the block clock. Each frame starts when chip select falls. The first byte is the opcode. The block then either streams response bytes MSB first, changing MISO after each SCK falling edge, or collects data bytes for a status write. A status write is held pending and is committed only when chip select rises on a byte boundary.

Top module: `flash_status_id`

## Requirements
- R1: The status byte reads, from bit 7 down: write lock, continuous-program flag, four protect bits (bits 5..2), write-enable latch (bit 1), and the live busy input (bit 0). After reset every stored bit is 0, and MISO is low whenever chip select is high.
- R2: Opcode 0x05 returns the status byte in every byte clocked after the opcode for as long as chip select stays low. Each copy reflects the busy input at the moment that byte is loaded.
- R3: Opcode 0x9F returns the manufacturer ID, then the memory type, then the device ID in the three bytes after the opcode. Later bytes read 0x00.
- R4: Opcode 0xAB returns 0x00 during three dummy bytes and the device ID in the fifth byte of the frame.
- R5: Opcode 0x90 takes two dummy bytes and a selector byte. A selector of 0x00 makes the next two bytes the manufacturer ID then the device ID. Any other selector gives the device ID then the manufacturer ID.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either takes effect as soon as the opcode byte completes.
- R7: Opcode 0x01 followed by one or two data bytes is committed when chip select rises on a byte boundary, provided the latch is set and bit 7 is clear. Status bits 7..2 take bits 7..2 of the first data byte, the latch clears, and a second data byte is discarded.
- R8: A status write leaves the status and the latch unchanged in each of these cases: the latch is clear, bit 7 is set, no data byte was sent, more than two data bytes were sent, or chip select rises mid-byte.
- R9: Any other opcode returns 0x00 and changes no status bit.
- R10: Transfers follow SPI mode 0: MOSI is sampled on SCK rising edges, MISO changes after falling edges, and both directions are MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Host-to-target serial data |
| busy | input | 1 | Sideband busy flag, shown as status bit 0 |
| miso | output | 1 | Target-to-host serial data |

## Verification
The identification opcodes are driven with asymmetric ID values. This separates byte order from bit order and shows an off-by-one in the dummy-byte counts. The ordered ID command is sent with selectors 0x00, 0x01 and 0x80, which shows whether the selector is treated as zero or non-zero. Status writes are tried with the latch clear, with the lock bit set, with one, two and three data bytes, and with chip select released mid-byte. Each case is followed by a status read, so an accepted write and an ignored write give different bytes. Reading with busy raised separates the live bit 0 from the stored bits.

// File: rtl/flash_sid_pkg.sv
package flash_sid_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_JDID = 8'h9F;
    localparam logic [7:0] OP_RSID = 8'hAB;
    localparam logic [7:0] OP_ODID = 8'h90;

    typedef struct packed {
        logic       lock;
        logic       cprog;
        logic [3:0] prot;
        logic       wel;
        logic       wip;
    } status_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_ONE  = 2'd1,
        WR_TWO  = 2'd2,
        WR_OVER = 2'd3
    } wr_cnt_e;

    function automatic logic [7:0] resp_byte(
        input logic [7:0]       op,
        input logic [IDX_W-1:0] idx,
        input logic             sel_zero,
        input status_t          st,
        input logic [7:0]       mfr,
        input logic [7:0]       mtype,
        input logic [7:0]       dev
    );
        logic [7:0] r;
        r = 8'h00;
        case (op)
            OP_RDSR: r = st;
            OP_JDID: begin
                if (idx == 3'd1) r = mfr;
                if (idx == 3'd2) r = mtype;
                if (idx == 3'd3) r = dev;
            end
            OP_RSID: if (idx == 3'd4) r = dev;
            OP_ODID: begin
                if (idx == 3'd4) r = sel_zero ? mfr : dev;
                if (idx == 3'd5) r = sel_zero ? dev : mfr;
            end
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_sid_edges.sv
module flash_sid_edges (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/flash_sid_shifter.sv
module flash_sid_shifter
    import flash_sid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] resp,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              bit_aligned,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            rx  <= '0;
            cnt <= '0;
        end else if (sck_rise) begin
            rx  <= byte_val;
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            tx <= '0;
        end else if (sck_fall) begin
            if (cnt == '0) tx <= resp;
            else           tx <= {tx[BYTE_W-2:0], 1'b0};
        end
    end

    assign byte_val    = {rx[BYTE_W-2:0], mosi};
    assign byte_done   = sck_rise && (cnt == CNT_W'(BYTE_W - 1));
    assign bit_aligned = (cnt == '0);
    assign miso        = tx[BYTE_W-1];
endmodule

// File: rtl/flash_sid_cmd.sv
module flash_sid_cmd
    import flash_sid_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              bit_aligned,
    input  logic              busy,
    output status_t           stat,
    output logic [BYTE_W-1:0] resp,
    output logic              opcode_phase
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [7:0]       cmd;
    logic [IDX_W-1:0] idx;
    logic             sel_zero;
    logic [7:0]       wr_data;
    wr_cnt_e          wr_cnt;
    logic             wel;
    logic             lock;
    logic             cprog;
    logic [3:0]       prot;
    logic             commit;

    assign commit = cs_rise && (cmd == OP_WRSR) && bit_aligned &&
                    (wr_cnt == WR_ONE || wr_cnt == WR_TWO) && wel && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= '0;
            idx      <= '0;
            sel_zero <= 1'b1;
            wr_data  <= '0;
            wr_cnt   <= WR_NONE;
            wel      <= 1'b0;
            lock     <= 1'b0;
            cprog    <= 1'b0;
            prot     <= '0;
        end else begin
            if (commit) begin
                lock  <= wr_data[7];
                cprog <= wr_data[6];
                prot  <= wr_data[5:2];
                wel   <= 1'b0;
            end
            if (cs_n) begin
                cmd      <= '0;
                idx      <= '0;
                sel_zero <= 1'b1;
                wr_cnt   <= WR_NONE;
            end else if (byte_done) begin
                if (idx == '0) begin
                    cmd <= byte_val;
                    if (byte_val == OP_WREN) wel <= 1'b1;
                    if (byte_val == OP_WRDI) wel <= 1'b0;
                end else begin
                    if (cmd == OP_WRSR) begin
                        if (idx == IDX_W'(1)) wr_data <= byte_val;
                        if (wr_cnt != WR_OVER) wr_cnt <= wr_cnt_e'(wr_cnt + 2'd1);
                    end
                    if (cmd == OP_ODID && idx == IDX_W'(3))
                        sel_zero <= (byte_val == 8'h00);
                end
                if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
        end
    end

    assign stat = '{lock: lock, cprog: cprog, prot: prot, wel: wel, wip: busy};
    assign resp = resp_byte(cmd, idx, sel_zero, stat, MFR_ID, MEM_TYPE, DEV_ID);
    assign opcode_phase = (idx == '0);
endmodule

// File: rtl/flash_status_id.sv
module flash_status_id
    import flash_sid_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic busy,
    output logic miso
);
    logic              sck_rise;
    logic              sck_fall;
    logic              cs_rise;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              bit_aligned;
    logic [BYTE_W-1:0] resp;
    status_t           stat;
    logic              opcode_phase;

    flash_sid_edges u_edges (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    flash_sid_shifter u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(mosi), .resp(resp),
        .byte_done(byte_done), .byte_val(byte_val),
        .bit_aligned(bit_aligned), .miso(miso)
    );

    flash_sid_cmd #(
        .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .DEV_ID(DEV_ID)
    ) u_cmd (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cs_rise(cs_rise),
        .byte_done(byte_done), .byte_val(byte_val), .bit_aligned(bit_aligned),
        .busy(busy), .stat(stat), .resp(resp), .opcode_phase(opcode_phase)
    );
endmodule

// File: rtl/flash_status_id_chk.sv
module flash_status_id_chk
    import flash_sid_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       miso,
    input status_t    stat,
    input logic       byte_done,
    input logic [7:0] byte_val,
    input logic       opcode_phase,
    input logic       cs_rise
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !miso); // R1

    AST_PROT_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !$past(cs_rise) |-> $stable(stat[7:2])); // R7

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(stat.lock) |-> (stat[7:2] == $past(stat[7:2]))); // R8

    AST_WEL_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.wel) |-> $past(byte_done && opcode_phase && byte_val == OP_WREN)); // R6

    AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.wel) |-> $past((byte_done && opcode_phase && byte_val == OP_WRDI) || cs_rise)); // R6
endmodule

bind flash_status_id flash_status_id_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso), .stat(stat),
    .byte_done(byte_done), .byte_val(byte_val),
    .opcode_phase(opcode_phase), .cs_rise(cs_rise)
);

// File: tb/flash_status_id_bench.sv
module flash_status_id_bench;
    localparam logic [7:0] MFR  = 8'hC2;
    localparam logic [7:0] MTYP = 8'h20;
    localparam logic [7:0] DEV  = 8'h17;
    localparam int HALF = 4;
    localparam int NV   = 7;

    typedef struct packed {
        logic [3:0]  len;
        logic [47:0] tx;
        logic [47:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd4, 48'h05_00_00_00_00_00, 48'h00_00_00_00_00_00}, // R2 status after reset
        '{4'd5, 48'h9F_00_00_00_00_00, 48'h00_C2_20_17_00_00}, // R3 R10
        '{4'd5, 48'hAB_00_00_00_00_00, 48'h00_00_00_00_17_00}, // R4
        '{4'd6, 48'h90_00_00_00_00_00, 48'h00_00_00_00_C2_17}, // R5 selector zero
        '{4'd6, 48'h90_00_00_01_00_00, 48'h00_00_00_00_17_C2}, // R5 selector one
        '{4'd6, 48'h90_00_00_80_00_00, 48'h00_00_00_00_17_C2}, // R5 selector high bit
        '{4'd3, 48'h03_00_00_00_00_00, 48'h00_00_00_00_00_00}  // R9 unknown opcode
    };
    localparam string VTAG [NV] = '{"R2", "R3/R10", "R4", "R5", "R5", "R5", "R9"};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic busy = 1'b0;
    logic miso;
    int   total = 0;
    int   fails = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    flash_status_id #(.MFR_ID(MFR), .MEM_TYPE(MTYP), .DEV_ID(DEV)) u_flash_status_id (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .busy(busy), .miso(miso)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] q);
        q = '0;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); mosi = d[i];
            repeat (HALF) @(negedge clk);
            q[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input int len, input logic [47:0] tx, output logic [47:0] rx);
        logic [7:0] q;
        rx = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < len; b++) begin
            xbits(tx[47-8*b -: 8], 8, q);
            rx[47-8*b -: 8] = q;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic status_is(input string tag, input logic [7:0] exp);
        logic [47:0] rx;
        frame(3, 48'h05_00_00_00_00_00, rx);
        chk(tag, rx[39:32], exp);
        chk(tag, rx[31:24], exp);
    endtask

    task automatic op(input int len, input logic [47:0] tx);
        logic [47:0] rx;
        frame(len, tx, rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [47:0] rx;
        logic [7:0]  q;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset miso", {7'd0, miso}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            frame(int'(VEC[v].len), VEC[v].tx, rx);
            for (int b = 1; b < int'(VEC[v].len); b++)
                chk(VTAG[v], rx[47-8*b -: 8], VEC[v].exp[47-8*b -: 8]);
        end

        op(2, 48'h01_3C_00_00_00_00);             // R8 latch clear
        status_is("R8 no latch", 8'h00);
        op(1, 48'h06_00_00_00_00_00);
        status_is("R6 set latch", 8'h02);
        op(1, 48'h04_00_00_00_00_00);
        status_is("R6 clear latch", 8'h00);

        op(1, 48'h06_00_00_00_00_00);
        op(2, 48'h01_3C_00_00_00_00);
        status_is("R7 one byte", 8'h3C);

        op(1, 48'h06_00_00_00_00_00);             // R8 release mid-byte
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xbits(8'h01, 8, q);
        xbits(8'hA8, 4, q);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
        status_is("R8 mid-byte", 8'h3E);
        op(1, 48'h01_00_00_00_00_00);             // R8 no data byte
        status_is("R8 no data", 8'h3E);

        op(1, 48'h04_00_00_00_00_00);
        op(1, 48'h06_00_00_00_00_00);
        op(3, 48'h01_54_FF_00_00_00);
        status_is("R7 two bytes", 8'h54);

        op(1, 48'h06_00_00_00_00_00);
        op(4, 48'h01_00_11_22_00_00);
        status_is("R8 three bytes", 8'h56);
        op(1, 48'h04_00_00_00_00_00);

        busy = 1'b1;
        status_is("R1 R2 busy", 8'h55);
        busy = 1'b0;

        op(1, 48'h06_00_00_00_00_00);
        op(2, 48'h01_80_00_00_00_00);
        status_is("R7 lock", 8'h80);
        op(1, 48'h06_00_00_00_00_00);
        op(2, 48'h01_3C_00_00_00_00);
        status_is("R8 locked", 8'h82);

        op(2, 48'h03_00_00_00_00_00);
        status_is("R9 no change", 8'h82);

        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        status_is("R1 after reset", 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule